// File: doc/BRIEF.md
# Rank Read-Priority Command Reorderer

This block takes the batch of pending commands buffered for one DRAM rank and reorders it before release, so that reads, and the writes they must observe, reach the rank's command queue as early as possible. A batch of up to eight commands is captured in one cycle. Each command carries a kind (read or write), a target address and a tag. Every write that a later read in the batch aliases is bound to that read. The write, together with any others bound to the same read, is placed directly in front of it, and these read-led groups fill the head of the output order. Writes with no later aliasing read are not held back. They follow the groups.

The reordered batch then drains one command per accepted cycle over a valid/ready pair, and a done flag marks the end of the batch. A new batch is taken only when the previous one has fully drained. DRAM timing, bank state, command encoding and power-mode control belong to other logic.

Top module: `rank_read_prio_reorder`

## Requirements
- R1: After reset, `out_valid_o` and `done_o` are both 0.
- R2: A write (kind bit 1) whose address equals that of a read (kind bit 0) arriving later in the batch joins that read's group and is emitted before the read.
- R3: Every read heads a group. Groups are emitted first, ordered by the arrival position of their reads.
- R4: A write joined to no group is still emitted. All such writes follow every group and keep their arrival order among themselves.
- R5: A write that matches several later reads joins the group of the earliest of those reads.
- R6: Within one group, the writes keep their arrival order among themselves.
- R7: Exactly one command leaves on each cycle with `out_valid_o` and `out_ready_i` both high. While `out_ready_i` is low, the presented command holds stable, and no command is lost or repeated.
- R8: A `load_i` pulse captures entries 0 to `load_cnt_i`-1, with the count clamped to DEPTH. Entries at or above the count are neither emitted nor matched against.
- R9: `done_o` rises the cycle after the last command is accepted, and stays high until the next accepted load. A load with count 0 raises it the cycle after the load.
- R10: A `load_i` pulse arriving while commands of the current batch remain is ignored.
- R11: A write that is younger than every same-address read in the batch stays ungrouped, so a read never sees data written after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture-batch pulse |
| load_cnt_i | input | CW=$clog2(DEPTH+1) | Number of valid entries in the batch |
| load_wr_i | input | DEPTH | Kind per entry: 1 write, 0 read |
| load_addr_i | input | DEPTH*AW | Address per entry, entry 0 in the low bits |
| load_id_i | input | DEPTH*IW | Tag per entry, entry 0 in the low bits |
| out_valid_o | output | 1 | A command is presented |
| out_ready_i | input | 1 | Queue accepts the presented command |
| out_wr_o | output | 1 | Kind of the presented command |
| out_addr_o | output | AW | Address of the presented command |
| out_id_o | output | IW | Tag of the presented command |
| done_o | output | 1 | Batch fully drained |

## Verification
A wrong group owner or sort key in this block shows up as a tag out of place in the drained sequence. The check catches it on the very beat where the misplaced command is presented, no more than DEPTH accepted cycles after the load. A broken drain pointer shows up at the ports as a repeated or skipped tag, or as data that changes during a stall, which the bench sees one cycle after the fault. A wrong done or batch-acceptance state shows up as a missing or early `done_o`, or as commands from a rejected batch appearing in the stream.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
  typedef enum logic {
    CMD_RD = 1'b0,
    CMD_WR = 1'b1
  } cmd_kind_e;

  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_AW    = 16;
  localparam int unsigned DEF_IW    = 4;
endpackage

// File: rtl/rrp_group_finder.sv
module rrp_group_finder
  import rrp_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned AW    = DEF_AW,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IXW  = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CW-1:0]                  cnt_i,
  input  logic [DEPTH-1:0]               wr_i,
  input  logic [DEPTH-1:0][AW-1:0]       addr_i,
  output logic [DEPTH-1:0]               vld_o,
  output logic [DEPTH-1:0]               grp_o,
  output logic [DEPTH-1:0][IXW-1:0]      own_o
);

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      vld_o[j] = (CW'(j) < cnt_i);
    end
  end

  // Owner search: a read owns itself; a write takes the earliest later read
  // with the same address (scan from high to low so the lowest index wins).
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      grp_o[j] = 1'b0;
      own_o[j] = IXW'(j);
      if (vld_o[j] && (cmd_kind_e'(wr_i[j]) == CMD_RD)) begin
        grp_o[j] = 1'b1;
      end else if (vld_o[j]) begin
        for (int k = DEPTH - 1; k >= 0; k--) begin
          if ((k > j) && vld_o[k] && (cmd_kind_e'(wr_i[k]) == CMD_RD) &&
              (addr_i[k] == addr_i[j])) begin
            grp_o[j] = 1'b1;
            own_o[j] = IXW'(k);
          end
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      // R2 / R11: a grouped write always points at a younger, aliasing read
      assert_grp_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o[g] && wr_i[g] && grp_o[g]) |->
          ((own_o[g] > IXW'(g)) && !wr_i[own_o[g]] && vld_o[own_o[g]] &&
           (addr_i[own_o[g]] == addr_i[g])));
    end
  endgenerate

endmodule

// File: rtl/rrp_order_sort.sv
module rrp_order_sort #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16,
  parameter int unsigned IW    = 4,
  localparam int unsigned IXW  = $clog2(DEPTH),
  localparam int unsigned KW   = 2 + 2 * IXW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          vld_i,
  input  logic [DEPTH-1:0]          grp_i,
  input  logic [DEPTH-1:0][IXW-1:0] own_i,
  input  logic [DEPTH-1:0]          wr_i,
  input  logic [DEPTH-1:0][AW-1:0]  addr_i,
  input  logic [DEPTH-1:0][IW-1:0]  id_i,
  output logic [DEPTH-1:0]          wr_o,
  output logic [DEPTH-1:0][AW-1:0]  addr_o,
  output logic [DEPTH-1:0][IW-1:0]  id_o
);

  logic [DEPTH-1:0][KW-1:0]  key;
  logic [DEPTH-1:0][IXW-1:0] pos;
  logic [DEPTH-1:0][DEPTH-1:0] hit; // hit[slot][entry]

  // Key: invalid last, ungrouped after groups, then owning read, then arrival.
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      key[j] = {~vld_i[j], ~grp_i[j], (grp_i[j] ? own_i[j] : IXW'(0)), IXW'(j)};
    end
  end

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      pos[j] = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (key[k] < key[j]) pos[j] = pos[j] + IXW'(1);
      end
    end
  end

  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      wr_o[s]   = 1'b0;
      addr_o[s] = '0;
      id_o[s]   = '0;
      for (int j = 0; j < DEPTH; j++) begin
        hit[s][j] = (pos[j] == IXW'(s));
        if (hit[s][j]) begin
          wr_o[s]   = wr_i[j];
          addr_o[s] = addr_i[j];
          id_o[s]   = id_i[j];
        end
      end
    end
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_perm
      // R8: the scatter is a permutation, each slot filled exactly once
      assert_slot_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit[s]) == 1);
    end
  endgenerate

endmodule

// File: rtl/rrp_out_stream.sv
module rrp_out_stream #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16,
  parameter int unsigned IW    = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IXW  = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [CW-1:0]            cnt_i,
  input  logic [DEPTH-1:0]         wr_i,
  input  logic [DEPTH-1:0][AW-1:0] addr_i,
  input  logic [DEPTH-1:0][IW-1:0] id_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic                     out_wr_o,
  output logic [AW-1:0]            out_addr_o,
  output logic [IW-1:0]            out_id_o,
  output logic                     done_o
);

  logic [DEPTH-1:0]         wr_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][IW-1:0] id_q;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [CW-1:0]            ptr_q, ptr_d;
  logic                     done_q, done_d;
  logic                     busy, fire, take;
  logic [IXW-1:0]           rd_ix;

  assign busy  = (ptr_q < cnt_q);
  assign fire  = busy && out_ready_i;
  assign take  = load_i && !busy;
  assign rd_ix = ptr_q[IXW-1:0];

  always_comb begin
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    done_d = done_q;
    if (take) begin
      cnt_d  = cnt_i;
      ptr_d  = '0;
      done_d = (cnt_i == '0);
    end else if (fire) begin
      ptr_d  = ptr_q + CW'(1);
      done_d = ((ptr_q + CW'(1)) == cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      addr_q <= '0;
      id_q   <= '0;
    end else if (take) begin
      wr_q   <= wr_i;
      addr_q <= addr_i;
      id_q   <= id_i;
    end
  end

  assign out_valid_o = busy;
  assign out_wr_o    = wr_q[rd_ix];
  assign out_addr_o  = addr_q[rd_ix];
  assign out_id_o    = id_q[rd_ix];
  assign done_o      = done_q;

  // R7: a stalled command stays presented and unchanged
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_id_o) && $stable(out_addr_o) && $stable(out_wr_o)));

  // R7: drain pointer never passes the batch size
  assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= cnt_q);

  // R9: done and a presented command never coexist
  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !out_valid_o);

  // R10: a load during a batch moves the pointer only by the handshake
  assert_load_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && busy) |=> (ptr_q == $past(ptr_q) + CW'($past(fire))));

endmodule

// File: rtl/rank_read_prio_reorder.sv
module rank_read_prio_reorder
  import rrp_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned AW    = DEF_AW,
  parameter int unsigned IW    = DEF_IW,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IXW  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [CW-1:0]       load_cnt_i,
  input  logic [DEPTH-1:0]    load_wr_i,
  input  logic [DEPTH*AW-1:0] load_addr_i,
  input  logic [DEPTH*IW-1:0] load_id_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                out_wr_o,
  output logic [AW-1:0]       out_addr_o,
  output logic [IW-1:0]       out_id_o,
  output logic                done_o
);

  logic [CW-1:0]             cnt_c;
  logic [DEPTH-1:0][AW-1:0]  in_addr;
  logic [DEPTH-1:0][IW-1:0]  in_id;
  logic [DEPTH-1:0]          vld, grp;
  logic [DEPTH-1:0][IXW-1:0] own;
  logic [DEPTH-1:0]          s_wr;
  logic [DEPTH-1:0][AW-1:0]  s_addr;
  logic [DEPTH-1:0][IW-1:0]  s_id;

  assign cnt_c = (load_cnt_i > CW'(DEPTH)) ? CW'(DEPTH) : load_cnt_i;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
      assign in_addr[g] = load_addr_i[g*AW +: AW];
      assign in_id[g]   = load_id_i[g*IW +: IW];
    end
  endgenerate

  rrp_group_finder #(.DEPTH(DEPTH), .AW(AW)) u_find (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt_c),
    .wr_i   (load_wr_i),
    .addr_i (in_addr),
    .vld_o  (vld),
    .grp_o  (grp),
    .own_o  (own)
  );

  rrp_order_sort #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_sort (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (vld),
    .grp_i  (grp),
    .own_i  (own),
    .wr_i   (load_wr_i),
    .addr_i (in_addr),
    .id_i   (in_id),
    .wr_o   (s_wr),
    .addr_o (s_addr),
    .id_o   (s_id)
  );

  rrp_out_stream #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .cnt_i       (cnt_c),
    .wr_i        (s_wr),
    .addr_i      (s_addr),
    .id_i        (s_id),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_wr_o    (out_wr_o),
    .out_addr_o  (out_addr_o),
    .out_id_o    (out_id_o),
    .done_o      (done_o)
  );

  // R1: nothing is presented and done is low right after reset release
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid_o && !done_o));

endmodule

// File: tb/tb_rank_read_prio_reorder.sv
module tb_rank_read_prio_reorder;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [CW-1:0] load_cnt_i = '0;
  logic [DEPTH-1:0] load_wr_i = '0;
  logic [DEPTH*AW-1:0] load_addr_i = '0;
  logic [DEPTH*IW-1:0] load_id_i = '0;
  logic out_valid_o, out_ready_i, out_wr_o, done_o;
  logic [AW-1:0] out_addr_o;
  logic [IW-1:0] out_id_o;

  always #2 clk = ~clk;

  rank_read_prio_reorder dut (.*);

  // cnt, kind mask (1=write), addr nibble per entry, expected tag order per slot (slot0 low)
  localparam int           V_CNT [NV] = '{8, 5, 4, 5, 3, 6};
  localparam logic [7:0]   V_WR  [NV] = '{8'hAF, 8'h1F, 8'h00, 8'h03, 8'h05, 8'h27};
  localparam logic [31:0]  V_ADR [NV] = '{32'h99355251, 32'h00043210, 32'h00003333,
                                          32'h00044847, 32'h00002332, 32'h00612121};
  localparam logic [31:0]  V_EXP [NV] = '{32'h75206431, 32'h00043210, 32'h00003210,
                                          32'h00004312, 32'h00000201, 32'h00542031};
  localparam logic [7:0]   V_STL [NV] = '{8'h00, 8'h5A, 8'h81, 8'h00, 8'h22, 8'h0C};
  localparam string        V_TAG [NV] = '{"R2 R3 R4 R11", "R4 R7", "R3 R7",
                                          "R5 R3", "R8 R11", "R6 R2"};

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_load(input int cnt, input logic [7:0] wr, input logic [31:0] adr);
    @(negedge clk);
    load_i = 1'b1;
    load_cnt_i = CW'(cnt);
    load_wr_i = wr;
    for (int j = 0; j < DEPTH; j++) begin
      load_addr_i[j*AW +: AW] = AW'(adr[4*j +: 4]);
      load_id_i[j*IW +: IW] = IW'(j);
    end
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic run_vec(input int v);
    int beat = 0;
    int cyc = 0;
    int eid;
    do_load(V_CNT[v], V_WR[v], V_ADR[v]);
    while (beat < V_CNT[v] && cyc < 200) begin
      out_ready_i = !V_STL[v][cyc % 8];
      #1;
      if (out_valid_o && out_ready_i) begin
        eid = int'(V_EXP[v][4*beat +: 4]);
        check(out_id_o == IW'(eid), V_TAG[v], out_id_o, eid);
        check(out_addr_o == AW'(V_ADR[v][4*eid +: 4]), V_TAG[v], out_addr_o,
              V_ADR[v][4*eid +: 4]);
        check(out_wr_o == V_WR[v][eid], V_TAG[v], out_wr_o, V_WR[v][eid]);
        beat++;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready_i = 1'b0;
    #1;
    check(done_o == 1'b1, "R9 done after last", done_o, 1);
    check(out_valid_o == 1'b0, "R7 no extra beat", out_valid_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    out_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid_o == 1'b0, "R1 valid", out_valid_o, 0);
    check(done_o == 1'b0, "R1 done", done_o, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R9: empty batch, done next cycle and held
    do_load(0, 8'h00, 32'h0);
    #1;
    check(done_o == 1'b1, "R9 empty load", done_o, 1);
    check(out_valid_o == 1'b0, "R9 empty valid", out_valid_o, 0);
    repeat (3) @(negedge clk);
    #1;
    check(done_o == 1'b1, "R9 done held", done_o, 1);

    // R7: stall holds the head command
    do_load(5, 8'h1F, 32'h00043210);
    #1;
    check(done_o == 1'b0, "R9 cleared by load", done_o, 0);
    for (int i = 0; i < 3; i++) begin
      check(out_valid_o && out_id_o == 0, "R7 stall hold", out_id_o, 0);
      @(negedge clk);
      #1;
    end
    out_ready_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      check(out_valid_o && out_id_o == IW'(i), "R7 drain after stall", out_id_o, i);
      @(negedge clk);
      #1;
    end
    out_ready_i = 1'b0;
    check(out_valid_o == 1'b0 && done_o == 1'b1, "R7 no dup", out_valid_o, 0);

    // R10: load during a batch is ignored
    do_load(4, 8'h00, 32'h00003333);
    out_ready_i = 1'b1;
    #1;
    check(out_id_o == 0, "R10 first", out_id_o, 0);
    @(negedge clk);
    out_ready_i = 1'b0;
    load_i = 1'b1;
    load_cnt_i = CW'(5);
    load_wr_i = 8'h1F;
    @(negedge clk);
    load_i = 1'b0;
    out_ready_i = 1'b1;
    for (int i = 1; i < 4; i++) begin
      #1;
      check(out_valid_o && out_id_o == IW'(i) && !out_wr_o, "R10 batch kept", out_id_o, i);
      @(negedge clk);
    end
    out_ready_i = 1'b0;
    #1;
    check(out_valid_o == 1'b0, "R10 no new batch", out_valid_o, 0);
    check(done_o == 1'b1, "R10 done", done_o, 1);
    finish_run();
  end
endmodule